// File: doc/BRIEF.md
# Serial Handshake Flow Controller

This block sits beside a UART and handles both directions of hardware handshaking. On the transmit side it takes the far end's active-low clear-to-send line and passes it through a two-stage synchronizer. When transmit handshaking is enabled, it grants the start of a new frame only while that line is low. A frame that is already being shifted out is never interrupted, because the block only gates frame starts. The same synchronized line feeds an edge detector, and a 2-bit selector picks which transitions set a sticky interrupt-pending flag.

On the receive side the block compares the receive FIFO fill count with a programmable trigger level. It drives an active-low request-to-send output high to ask the remote transmitter to pause. A software bit can force the pause at any time. The shifters and the FIFO storage sit outside the block; only counts, enables and handshake strobes cross its ports.

Top module: `fc_flow_ctrl`

## Requirements
- R1: While reset is applied, and on the first clock after it, `tx_start` is 0, `irq_pending` is 0 and `rts_n_out` is 1.
- R2: With `tx_fc_en` = 0, `tx_start` equals `tx_start_req & ~tx_busy` registered one cycle, whatever the level of `cts_n_in`.
- R3: With `tx_fc_en` = 1, `tx_start` is 1 only if the synchronized `cts_n_in` is 0 (low means the far end accepts data).
- R4: `tx_start` is never 1 in the cycle after one in which `tx_busy` was 1.
- R5: A change on `cts_n_in` made between clock edges reaches `tx_start` on the third rising edge after the change, not earlier.
- R6: `irq_sel` encodes 00 = no interrupt, 01 = low-to-high of `cts_n_in`, 10 = high-to-low, 11 = either. A selected transition of the synchronized input sets `irq_pending`, and the flag stays set.
- R7: A one-cycle pulse on `irq_clr` clears `irq_pending` on the next edge. With `irq_clr` at 0 the flag holds.
- R8: With `rx_fc_en` = 1 and `rts_sw` = 0, `rts_n_out` is 1 when `rx_level >= rx_trig` and 0 when `rx_level < rx_trig`, one clock after the inputs.
- R9: `rts_sw` = 1 forces `rts_n_out` to 1 one clock later, whatever the FIFO level.
- R10: With `rx_fc_en` = 0, `rts_n_out` follows `rts_sw` alone, one clock later.
- R11: A trigger level of 0 with `rx_fc_en` = 1 keeps `rts_n_out` at 1 even with an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_in | input | 1 | Asynchronous clear-to-send from far end, active low |
| tx_fc_en | input | 1 | Enable gating of frame starts by clear-to-send |
| tx_start_req | input | 1 | Transmitter has a byte and wants to start a frame |
| tx_busy | input | 1 | Transmitter is shifting a frame |
| tx_start | output | 1 | Registered permission to start a frame |
| irq_sel | input | 2 | Interrupt condition: 00 off, 01 rise, 10 fall, 11 both |
| irq_clr | input | 1 | Write-one pulse clearing the pending flag |
| irq_pending | output | 1 | Sticky clear-to-send change interrupt |
| rx_fc_en | input | 1 | Enable request-to-send from FIFO level |
| rx_level | input | CW | Receive FIFO fill count (CW = clog2(DEPTH+1), 5 by default) |
| rx_trig | input | CW | Fill level at which a pause is requested |
| rts_sw | input | 1 | Software force of pause |
| rts_n_out | output | 1 | Request-to-send, high asks remote to pause |

## Verification
The assertions assume that `tx_busy`, `tx_start_req`, `irq_clr` and the receive-side inputs are synchronous to `clk` and that `rx_level` never exceeds the FIFO depth. The bench drives every input on the falling edge and draws counts from the range 0 to DEPTH. Only `cts_n_in` is treated as asynchronous. The stimulus holds each value of it for several cycles, and it pulses `irq_clr` in a cycle of its own, separate from any clear-to-send transition. Because of this, the expected pending flag never depends on how a set and a clear in the same cycle are ordered.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_RISE = 2'b01,
    IRQ_FALL = 2'b10,
    IRQ_BOTH = 2'b11
  } irq_sel_e;

  function automatic logic edge_hit(irq_sel_e sel, logic rise, logic fall);
    case (sel)
      IRQ_RISE: edge_hit = rise;
      IRQ_FALL: edge_hit = fall;
      IRQ_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_s,
  input  logic       tx_fc_en,
  input  logic       tx_start_req,
  input  logic       tx_busy,
  input  logic [1:0] irq_sel,
  input  logic       irq_clr,
  output logic       tx_start,
  output logic       irq_pending
);
  logic cts_d;
  logic hit;

  assign hit = edge_hit(irq_sel_e'(irq_sel), cts_s & ~cts_d, ~cts_s & cts_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_d       <= 1'b1;
      tx_start    <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      cts_d    <= cts_s;
      tx_start <= tx_start_req & ~tx_busy & (~tx_fc_en | ~cts_s);
      if (hit)          irq_pending <= 1'b1;
      else if (irq_clr) irq_pending <= 1'b0;
    end
  end

  a_r4_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !tx_start);
  a_r3_held_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (tx_fc_en && cts_s) |=> !tx_start);
  a_r6_set_needs_selector: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> $past(irq_sel != 2'b00));
  a_r7_clear_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_pending) |-> $past(irq_clr));
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_fc_en,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] rx_trig,
  input  logic          rts_sw,
  output logic          rts_n_out
);
  logic level_hit;

  assign level_hit = rx_fc_en && (rx_level >= rx_trig);

  always_ff @(posedge clk) begin
    if (rst) rts_n_out <= 1'b1;
    else     rts_n_out <= rts_sw | level_hit;
  end

  a_r9_sw_forces_pause: assert property (@(posedge clk) disable iff (rst)
    rts_sw |=> rts_n_out);
  a_r10_disabled_follows_sw: assert property (@(posedge clk) disable iff (rst)
    (!rx_fc_en && !rts_sw) |=> !rts_n_out);
  a_r8_below_trig_releases: assert property (@(posedge clk) disable iff (rst)
    (rx_fc_en && !rts_sw && rx_level < rx_trig) |=> !rts_n_out);
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cts_n_in,
  input  logic          tx_fc_en,
  input  logic          tx_start_req,
  input  logic          tx_busy,
  output logic          tx_start,
  input  logic [1:0]    irq_sel,
  input  logic          irq_clr,
  output logic          irq_pending,
  input  logic          rx_fc_en,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] rx_trig,
  input  logic          rts_sw,
  output logic          rts_n_out
);
  logic cts_s;

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(cts_n_in), .sync_out(cts_s)
  );

  fc_tx_gate u_tx (
    .clk(clk), .rst(rst), .cts_s(cts_s), .tx_fc_en(tx_fc_en),
    .tx_start_req(tx_start_req), .tx_busy(tx_busy), .irq_sel(irq_sel),
    .irq_clr(irq_clr), .tx_start(tx_start), .irq_pending(irq_pending)
  );

  fc_rts_ctrl #(.CW(CW)) u_rts (
    .clk(clk), .rst(rst), .rx_fc_en(rx_fc_en), .rx_level(rx_level),
    .rx_trig(rx_trig), .rts_sw(rts_sw), .rts_n_out(rts_n_out)
  );

  a_r1_reset_values: assert property (@(posedge clk)
    $past(rst) |-> (!tx_start && !irq_pending && rts_n_out));
endmodule

// File: tb/test_fc_flow_ctrl.sv
module test_fc_flow_ctrl;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n_in = 1'b1, tx_fc_en = 1'b0, tx_start_req = 1'b0, tx_busy = 1'b0;
  logic [1:0] irq_sel = 2'b00;
  logic irq_clr = 1'b0, rx_fc_en = 1'b0, rts_sw = 1'b0;
  logic [CW-1:0] rx_level = '0, rx_trig = '0;
  logic tx_start, irq_pending, rts_n_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fc_flow_ctrl #(.DEPTH(DEPTH)) i_fc_flow_ctrl (
    .clk(clk), .rst(rst), .cts_n_in(cts_n_in), .tx_fc_en(tx_fc_en),
    .tx_start_req(tx_start_req), .tx_busy(tx_busy), .tx_start(tx_start),
    .irq_sel(irq_sel), .irq_clr(irq_clr), .irq_pending(irq_pending),
    .rx_fc_en(rx_fc_en), .rx_level(rx_level), .rx_trig(rx_trig),
    .rts_sw(rts_sw), .rts_n_out(rts_n_out)
  );

  function automatic logic exp_grant(logic req, logic busy, logic en, logic cts);
    return req && !busy && (!en || !cts);
  endfunction

  function automatic logic exp_rts(logic en, int lvl, int trig, logic sw);
    return sw || (en && lvl >= trig);
  endfunction

  function automatic logic exp_hit(logic [1:0] sel, logic old_v, logic new_v);
    logic rise, fall;
    rise = !old_v && new_v;
    fall = old_v && !new_v;
    case (sel)
      2'b01:   return rise;
      2'b10:   return fall;
      2'b11:   return rise || fall;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cycles(1);
    check("R1 tx_start in reset", tx_start, 1'b0);
    check("R1 irq_pending in reset", irq_pending, 1'b0);
    check("R1 rts_n_out in reset", rts_n_out, 1'b1);
    cycles(2);
    rst = 1'b0;
    cycles(1);
    check("R1 tx_start after reset", tx_start, 1'b0);
    check("R1 irq_pending after reset", irq_pending, 1'b0);

    // R5: latency of CTS through synchronizer to grant
    cts_n_in = 1'b0; tx_fc_en = 1'b1; tx_start_req = 1'b1;
    cycles(4);
    check("R3 grant with cts low", tx_start, 1'b1);
    cts_n_in = 1'b1;
    cycles(2);
    check("R5 grant not yet blocked after two edges", tx_start, 1'b1);
    cycles(1);
    check("R5 grant blocked on third edge", tx_start, 1'b0);

    // R2: flow control off ignores CTS
    tx_fc_en = 1'b0;
    cycles(1);
    check("R2 grant ignores cts when disabled", tx_start, 1'b1);

    // R4: busy blocks grant
    tx_busy = 1'b1;
    cycles(1);
    check("R4 no grant while busy", tx_start, 1'b0);
    tx_busy = 1'b0; tx_start_req = 1'b0;

    // R6 / R7 directed: falling edge selected
    irq_sel = 2'b10;
    cts_n_in = 1'b0;
    cycles(4);
    check("R6 falling edge sets pending", irq_pending, 1'b1);
    cycles(3);
    check("R7 pending holds without clear", irq_pending, 1'b1);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    check("R7 clear pulse drops pending", irq_pending, 1'b0);
    cts_n_in = 1'b1;
    cycles(4);
    check("R6 rising edge ignored under fall select", irq_pending, 1'b0);

    // R8 / R11 boundaries
    rx_fc_en = 1'b1; rx_trig = CW'(8); rx_level = CW'(8);
    cycles(1);
    check("R8 level equal to trigger pauses", rts_n_out, 1'b1);
    rx_level = CW'(7);
    cycles(1);
    check("R8 level below trigger releases", rts_n_out, 1'b0);
    rts_sw = 1'b1;
    cycles(1);
    check("R9 software bit forces pause", rts_n_out, 1'b1);
    rts_sw = 1'b0; rx_fc_en = 1'b0; rx_level = CW'(DEPTH);
    cycles(1);
    check("R10 disabled full fifo no pause", rts_n_out, 1'b0);
    rx_fc_en = 1'b1; rx_trig = '0; rx_level = '0;
    cycles(1);
    check("R11 zero trigger pauses on empty fifo", rts_n_out, 1'b1);

    // Constrained random
    begin
      int seed_dummy;
      logic cur_cts, exp_pend;
      seed_dummy = $urandom(32'h5eed_0042);
      cur_cts = cts_n_in;
      exp_pend = irq_pending;
      for (int it = 0; it < 400; it++) begin
        logic new_cts;
        int lvl, trg;
        if ($urandom_range(0, 3) == 0) begin
          irq_clr = 1'b1;
          cycles(1);
          irq_clr = 1'b0;
          exp_pend = 1'b0;
          check("R7 random clear", irq_pending, 1'b0);
        end
        new_cts      = 1'($urandom_range(0, 1));
        irq_sel      = 2'($urandom_range(0, 3));
        tx_fc_en     = 1'($urandom_range(0, 1));
        tx_start_req = 1'($urandom_range(0, 1));
        tx_busy      = ($urandom_range(0, 3) == 0);
        rx_fc_en     = 1'($urandom_range(0, 1));
        rts_sw       = ($urandom_range(0, 4) == 0);
        lvl          = $urandom_range(0, DEPTH);
        trg          = $urandom_range(0, DEPTH);
        rx_level     = CW'(lvl);
        rx_trig      = CW'(trg);
        cts_n_in     = new_cts;
        if (exp_hit(irq_sel, cur_cts, new_cts)) exp_pend = 1'b1;
        cur_cts = new_cts;
        cycles(4);
        if (tx_fc_en) check("R3 random grant", tx_start,
                            exp_grant(tx_start_req, tx_busy, tx_fc_en, cur_cts));
        else          check("R2 random grant", tx_start,
                            exp_grant(tx_start_req, tx_busy, tx_fc_en, cur_cts));
        check("R6 random pending", irq_pending, exp_pend);
        if (rts_sw)        check("R9 random rts", rts_n_out, 1'b1);
        else if (rx_fc_en) check("R8 random rts", rts_n_out, exp_rts(1'b1, lvl, trg, 1'b0));
        else               check("R10 random rts", rts_n_out, 1'b0);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule